// File: doc/BRIEF.md
# Toggle-Pattern Digitally Controlled Oscillator

This block is the oscillator stage of an all-digital phase-locked loop. A single toggle register runs on a free-running reference clock and changes state on every edge, so the output enable fires in every second reference cycle. A loop filter nudges the output phase with single-cycle requests. A speed-up request removes one high interval from the toggle pattern, so the next output pulse comes one reference period early. A slow-down request stretches one high interval to two reference periods, so the next output pulse comes one reference period late.

A request is acted on only in the toggle state that suits it. A speed-up is taken while the toggle register is high. A slow-down is taken while it is low. A request that arrives in the other state, or during the extra interval of an earlier correction, waits in a one-deep pending slot. This bounds the output rate between one third and two thirds of the reference clock. The output is a one-cycle enable that is meant for logic clocked by the reference clock; it is not a derived clock.

Top module: `inc_dec_dco`

## Requirements
- R1: While `rst` is high at a rising edge, the block returns to its idle state: `phase_o` is 1, and `pulse_o`, `pending_o` and `overrun_o` are 0.
- R2: `pulse_o` is 1 exactly in the cycles where `phase_o` is 0. With no request present or pending, `phase_o` inverts on every rising edge, which gives one pulse every two cycles.
- R3: A speed-up request (`carry_i`=1, `borrow_i`=0) seen at an edge where `phase_o` is 1 drives `phase_o` to 0 at that edge. `phase_o` holds 0 at the next edge and then resumes toggling.
- R4: A speed-up request seen while `phase_o` is 0 sets `pending_o`. `phase_o` toggles to 1, and the pending request is then serviced as in R3 at the next edge.
- R5: A slow-down request (`borrow_i`=1, `carry_i`=0) seen at an edge where `phase_o` is 0 drives `phase_o` to 1 at that edge. `phase_o` holds 1 at the next edge and then resumes toggling.
- R6: A slow-down request seen while `phase_o` is 1 sets `pending_o`. `phase_o` toggles to 0, and the pending request is then serviced as in R5 at the next edge.
- R7: With a speed-up request in every cycle, `phase_o` is never 0 at three edges in a row. The pattern settles to low-low-high, which gives 20 pulses in 30 cycles after reset.
- R8: With a slow-down request in every cycle, `phase_o` is never 1 at three edges in a row. The pattern settles to low-high-high, which gives 10 pulses in 30 cycles after reset.
- R9: A request of the same kind as one already pending is dropped. `overrun_o` is then 1 for the one cycle after that edge.
- R10: A speed-up and a slow-down request in the same cycle cancel. Nothing is latched, and `phase_o` toggles as if idle.
- R11: A request of the opposite kind to a pending one cancels it. `pending_o` clears and `phase_o` toggles as if idle.
- R12: At the edge that ends a correction's extra interval, `phase_o` does not change, and a new request seen at that edge is latched as pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| carry_i | input | 1 | One-cycle speed-up request from the loop filter |
| borrow_i | input | 1 | One-cycle slow-down request from the loop filter |
| pulse_o | output | 1 | Output enable, high in each cycle the toggle register is low |
| phase_o | output | 1 | Current toggle register state |
| pending_o | output | 1 | A request is latched and waiting for service |
| overrun_o | output | 1 | One-cycle flag: a same-kind request was dropped |

## Verification
The rate-bound assertions depend on a property of the block, not of its inputs: no request pattern can produce three equal toggle states in a row. They therefore hold for any value on `carry_i` and `borrow_i`. The idle-toggle and cancellation assertions assume the request inputs are stable at the sampling edge. The stimulus meets this by changing the requests only just after a rising edge and clearing them after one cycle, unless a test holds them for a continuous run. The overrun assertion assumes that reset has been held long enough for the pending slot to hold a known value. The bench keeps reset high for three edges before every scenario.

// File: rtl/inc_dec_dco.sv
module inc_dec_dco (
  input  logic clk,
  input  logic rst,
  input  logic carry_i,
  input  logic borrow_i,
  output logic pulse_o,
  output logic phase_o,
  output logic pending_o,
  output logic overrun_o
);

  logic phase_q, hold_q, pend_up_q, pend_dn_q, ovr_q;
  logic up_new, dn_new, up_eff, dn_eff;
  logic svc_up, svc_dn;

  assign up_new = carry_i & ~borrow_i;
  assign dn_new = borrow_i & ~carry_i;

  assign up_eff = (pend_up_q & ~dn_new) | (up_new & ~pend_dn_q);
  assign dn_eff = (pend_dn_q & ~up_new) | (dn_new & ~pend_up_q);

  assign svc_up = ~hold_q & up_eff & phase_q;
  assign svc_dn = ~hold_q & dn_eff & ~phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= 1'b1;
      hold_q    <= 1'b0;
      pend_up_q <= 1'b0;
      pend_dn_q <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      phase_q   <= hold_q ? phase_q : ~phase_q;
      hold_q    <= svc_up | svc_dn;
      pend_up_q <= up_eff & ~svc_up;
      pend_dn_q <= dn_eff & ~svc_dn;
      ovr_q     <= (pend_up_q & up_new) | (pend_dn_q & dn_new);
    end
  end

  assign phase_o   = phase_q;
  assign pulse_o   = ~phase_q;
  assign pending_o = pend_up_q | pend_dn_q;
  assign overrun_o = ovr_q;

endmodule

// File: rtl/inc_dec_dco_chk.sv
module inc_dec_dco_chk (
  input logic clk,
  input logic rst,
  input logic carry_i,
  input logic borrow_i,
  input logic phase_o,
  input logic pending_o,
  input logic overrun_o,
  input logic hold_q
);

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (phase_o && !pending_o && !overrun_o)); // R1

  AST_IDLE_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (!hold_q && !carry_i && !borrow_i && !pending_o) |=> (phase_o != $past(phase_o))); // R2

  AST_MAX_RATE: assert property (@(posedge clk) disable iff (rst)
    (!phase_o && !$past(phase_o)) |=> phase_o); // R7

  AST_MIN_RATE: assert property (@(posedge clk) disable iff (rst)
    (phase_o && $past(phase_o)) |=> !phase_o); // R8

  AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (rst)
    overrun_o |-> $past(pending_o)); // R9

  AST_SAME_CYCLE_CANCEL: assert property (@(posedge clk) disable iff (rst)
    (carry_i && borrow_i && !pending_o) |=> !pending_o); // R10

  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (rst)
    hold_q |=> (phase_o == $past(phase_o))); // R12

endmodule

bind inc_dec_dco inc_dec_dco_chk u_chk (
  .clk(clk), .rst(rst), .carry_i(carry_i), .borrow_i(borrow_i),
  .phase_o(phase_o), .pending_o(pending_o), .overrun_o(overrun_o),
  .hold_q(hold_q)
);

// File: tb/inc_dec_dco_bench.sv
`timescale 1ns/1ps
module inc_dec_dco_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic carry_i = 1'b0;
  logic borrow_i = 1'b0;
  logic pulse_o, phase_o, pending_o, overrun_o;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  inc_dec_dco u_inc_dec_dco (
    .clk(clk), .rst(rst), .carry_i(carry_i), .borrow_i(borrow_i),
    .pulse_o(pulse_o), .phase_o(phase_o),
    .pending_o(pending_o), .overrun_o(overrun_o)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(bit c, bit b);
    carry_i = c;
    borrow_i = b;
    @(posedge clk);
    #1;
    carry_i = 1'b0;
    borrow_i = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1 phase", phase_o, 1);
    check("R1 pulse", pulse_o, 0);
    check("R1 pending", pending_o, 0);
    check("R1 overrun", overrun_o, 0);
    do_reset();
  endtask

  task automatic t_free_run();
    do_reset();
    for (int k = 1; k <= 8; k++) begin
      cyc(0, 0);
      check("R2 phase", phase_o, (k % 2 == 0) ? 1 : 0);
      check("R2 pulse", pulse_o, (k % 2 == 1) ? 1 : 0);
    end
  endtask

  task automatic t_carry_high();
    do_reset();
    cyc(1, 0); check("R3 phase e1", phase_o, 0); check("R3 pending", pending_o, 0);
    cyc(0, 0); check("R3 phase e2", phase_o, 0);
    cyc(0, 0); check("R3 phase e3", phase_o, 1);
    cyc(0, 0); check("R3 phase e4", phase_o, 0);
  endtask

  task automatic t_carry_low();
    do_reset();
    cyc(0, 0);
    cyc(1, 0); check("R4 phase e1", phase_o, 1); check("R4 pending", pending_o, 1);
    cyc(0, 0); check("R4 phase e2", phase_o, 0); check("R4 pending clr", pending_o, 0);
    cyc(0, 0); check("R4 phase e3", phase_o, 0);
    cyc(0, 0); check("R4 phase e4", phase_o, 1);
  endtask

  task automatic t_borrow_low();
    do_reset();
    cyc(0, 0);
    cyc(0, 1); check("R5 phase e1", phase_o, 1); check("R5 pending", pending_o, 0);
    cyc(0, 0); check("R5 phase e2", phase_o, 1);
    cyc(0, 0); check("R5 phase e3", phase_o, 0);
  endtask

  task automatic t_borrow_high();
    do_reset();
    cyc(0, 1); check("R6 phase e1", phase_o, 0); check("R6 pending", pending_o, 1);
    cyc(0, 0); check("R6 phase e2", phase_o, 1); check("R6 pending clr", pending_o, 0);
    cyc(0, 0); check("R6 phase e3", phase_o, 1);
    cyc(0, 0); check("R6 phase e4", phase_o, 0);
  endtask

  task automatic t_carry_stream();
    int pulses = 0;
    int ovr = 0;
    do_reset();
    for (int k = 0; k < 30; k++) begin
      cyc(1, 0);
      pulses += pulse_o;
      ovr += overrun_o;
    end
    check("R7 pulse count", pulses, 20);
    check("R9 overrun seen in carry stream", (ovr > 0) ? 1 : 0, 1);
  endtask

  task automatic t_borrow_stream();
    int pulses = 0;
    do_reset();
    for (int k = 0; k < 30; k++) begin
      cyc(0, 1);
      pulses += pulse_o;
    end
    check("R8 pulse count", pulses, 10);
  endtask

  task automatic t_overrun();
    do_reset();
    cyc(1, 0); check("R9 phase e1", phase_o, 0);
    cyc(1, 0); check("R12 phase held", phase_o, 0); check("R12 latched", pending_o, 1);
    check("R9 no overrun yet", overrun_o, 0);
    cyc(1, 0); check("R9 overrun", overrun_o, 1); check("R9 phase e3", phase_o, 1);
    cyc(0, 0); check("R9 overrun clr", overrun_o, 0); check("R9 serviced", phase_o, 0);
    check("R9 pending clr", pending_o, 0);
    cyc(0, 0); check("R9 phase e5", phase_o, 0);
    cyc(0, 0); check("R9 dropped no effect", phase_o, 1);
    cyc(0, 0); check("R9 phase e7", phase_o, 0);
  endtask

  task automatic t_same_cycle();
    do_reset();
    cyc(1, 1); check("R10 phase", phase_o, 0); check("R10 pending", pending_o, 0);
    cyc(0, 0); check("R10 phase e2", phase_o, 1);
    cyc(0, 0); check("R10 phase e3", phase_o, 0);
  endtask

  task automatic t_cancel_pending();
    do_reset();
    cyc(0, 0);
    cyc(1, 0); check("R11 pending set", pending_o, 1);
    cyc(0, 1); check("R11 pending clr", pending_o, 0); check("R11 phase", phase_o, 0);
    cyc(0, 0); check("R11 phase e2", phase_o, 1);
    cyc(0, 0); check("R11 phase e3", phase_o, 0);
  endtask

  initial begin
    t_reset();
    t_free_run();
    t_carry_high();
    t_carry_low();
    t_borrow_low();
    t_borrow_high();
    t_carry_stream();
    t_borrow_stream();
    t_overrun();
    t_same_cycle();
    t_cancel_pending();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule